// File: doc/BRIEF.md
# Chip-Select Output Bank

This block drives a bank of general-purpose output lines that a serial peripheral interface controller uses as chip selects. Each line either follows a chip-select strobe supplied by the serial engine or holds a level stored in the block, and each line can be inverted on its way to the pin. After reset, every line is a stored-level output and every line is high, which is the inactive level.

Software changes the stored levels through one write-only drive register. The upper half of a write raises lines and the lower half lowers them, so any group of lines can move in a single write. Bits written as zero leave their lines as they are. A second register holds two fields for each line. One field gives the line to the serial engine, and the other inverts the pin.

Register port: `addr_i` selects a register. A write happens on a rising clock edge while `wr_en_i` is high. `rdata_o` shows the addressed register in the same cycle.

Top module: `cs_out_ctrl`

## Requirements
- R1: After reset the setup register (address 0) reads 0x0000, and every bit of `pins_o` is 1.
- R2: A write to address 0 stores the data. Bits 15:8 are the engine-ownership flags for lines 7..0, and bits 7:0 are the inversion flags for lines 7..0. From the next cycle, address 0 reads back the stored value.
- R3: A write to address 1 with bit 8+n set makes the stored level of line n equal to 1 from the next cycle.
- R4: A write to address 1 with bit n set, and bit 8+n clear, makes the stored level of line n equal to 0 from the next cycle.
- R5: Stored levels whose set and clear bits are both zero in an address-1 write keep their value. Stored levels also keep their value in any cycle without an address-1 write.
- R6: When bit 8+n and bit n are both 1 in one address-1 write, line n is set to 1.
- R7: For a line whose ownership flag is 0, the pin equals its stored level XOR its inversion flag.
- R8: For a line whose ownership flag is 1, the pin equals `hw_cs_i[n]` XOR its inversion flag. Writes to address 1 still update the stored level of that line, and the stored level appears on the pin once ownership is released.
- R9: Address 1 and the unused addresses 2 and 3 always read 0. Writes to addresses 2 and 3 change neither the registers nor the pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i` |
| hw_cs_i | input | 8 | Chip-select strobes from the serial engine |
| pins_o | output | 8 | Output lines |

## Verification
The bench aims at the write where set and clear hit the same line. A design that gave priority to clear would leave that line low. It also checks that zero bits in a drive write leave their lines alone; a design that treated the drive register as a plain stored register would wipe the other lines. Engine-owned lines are checked in two ways. The pin must follow the engine strobe through the inversion flag. The stored level must still be updated in the background, which catches a design that ignores drive writes for owned lines or leaks the stored level onto the pin. Reads of the drive register and writes to unused addresses are checked for leaks into the read data or the pins.

// File: rtl/cs_ctrl_pkg.sv
package cs_ctrl_pkg;
  parameter int unsigned CS_LINES = 8;
  parameter int unsigned REG_AW   = 2;
  localparam logic [REG_AW-1:0] ADDR_SETUP = 2'd0;
  localparam logic [REG_AW-1:0] ADDR_DRIVE = 2'd1;
endpackage

// File: rtl/cs_setup_reg.sv
module cs_setup_reg #(
  parameter int unsigned NUM_LINES = 8,
  localparam int unsigned DW = 2 * NUM_LINES
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic [DW-1:0]        wdata_i,
  output logic [NUM_LINES-1:0] own_o,
  output logic [NUM_LINES-1:0] inv_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      own_o <= '0;
      inv_o <= '0;
    end else if (wr_i) begin
      own_o <= wdata_i[DW-1:NUM_LINES];
      inv_o <= wdata_i[NUM_LINES-1:0];
    end
  end
endmodule

// File: rtl/cs_drive_reg.sv
module cs_drive_reg #(
  parameter int unsigned NUM_LINES = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_i,
  input  logic [NUM_LINES-1:0] set_i,
  input  logic [NUM_LINES-1:0] clr_i,
  output logic [NUM_LINES-1:0] lvl_o
);
  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                lvl_o[n] <= 1'b1;
      else if (wr_i && set_i[n])  lvl_o[n] <= 1'b1; // set wins
      else if (wr_i && clr_i[n])  lvl_o[n] <= 1'b0;
    end
  end
endmodule

// File: rtl/cs_pin_mux.sv
module cs_pin_mux #(
  parameter int unsigned NUM_LINES = 8
) (
  input  logic [NUM_LINES-1:0] own_i,
  input  logic [NUM_LINES-1:0] inv_i,
  input  logic [NUM_LINES-1:0] lvl_i,
  input  logic [NUM_LINES-1:0] hw_cs_i,
  output logic [NUM_LINES-1:0] pin_o
);
  for (genvar n = 0; n < NUM_LINES; n++) begin : g_pin
    assign pin_o[n] = (own_i[n] ? hw_cs_i[n] : lvl_i[n]) ^ inv_i[n];
  end
endmodule

// File: rtl/cs_out_ctrl.sv
module cs_out_ctrl
  import cs_ctrl_pkg::*;
#(
  parameter int unsigned NUM_LINES = CS_LINES,
  localparam int unsigned DW = 2 * NUM_LINES
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 wr_en_i,
  input  logic [REG_AW-1:0]    addr_i,
  input  logic [DW-1:0]        wdata_i,
  output logic [DW-1:0]        rdata_o,
  input  logic [NUM_LINES-1:0] hw_cs_i,
  output logic [NUM_LINES-1:0] pins_o
);
  logic                 setup_wr, drive_wr;
  logic [NUM_LINES-1:0] own_q, inv_q, lvl_q;

  assign setup_wr = wr_en_i && (addr_i == ADDR_SETUP);
  assign drive_wr = wr_en_i && (addr_i == ADDR_DRIVE);

  cs_setup_reg #(.NUM_LINES(NUM_LINES)) u_setup (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (setup_wr),
    .wdata_i(wdata_i),
    .own_o  (own_q),
    .inv_o  (inv_q)
  );

  cs_drive_reg #(.NUM_LINES(NUM_LINES)) u_drive (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (drive_wr),
    .set_i  (wdata_i[DW-1:NUM_LINES]),
    .clr_i  (wdata_i[NUM_LINES-1:0]),
    .lvl_o  (lvl_q)
  );

  cs_pin_mux #(.NUM_LINES(NUM_LINES)) u_mux (
    .own_i  (own_q),
    .inv_i  (inv_q),
    .lvl_i  (lvl_q),
    .hw_cs_i(hw_cs_i),
    .pin_o  (pins_o)
  );

  // drive register is write-only
  always_comb begin
    rdata_o = '0;
    if (addr_i == ADDR_SETUP) rdata_o = {own_q, inv_q};
  end
endmodule

// File: rtl/cs_out_ctrl_chk.sv
module cs_out_ctrl_chk #(
  parameter int unsigned NUM_LINES = 8,
  localparam int unsigned DW = 2 * NUM_LINES
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 wr_en_i,
  input logic [1:0]           addr_i,
  input logic [DW-1:0]        wdata_i,
  input logic [DW-1:0]        rdata_o,
  input logic [NUM_LINES-1:0] hw_cs_i,
  input logic [NUM_LINES-1:0] pins_o,
  input logic [NUM_LINES-1:0] own_q,
  input logic [NUM_LINES-1:0] inv_q,
  input logic [NUM_LINES-1:0] lvl_q
);
  // R2
  setup_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 2'd0) |=> ({own_q, inv_q} == $past(wdata_i)));

  // R6
  drive_update_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 2'd1) |=>
      (lvl_q == (($past(lvl_q) & ~$past(wdata_i[NUM_LINES-1:0])) | $past(wdata_i[DW-1:NUM_LINES]))));

  // R5
  drive_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == 2'd1) |=> $stable(lvl_q));

  // R8
  pin_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pins_o == (((own_q & hw_cs_i) | (~own_q & lvl_q)) ^ inv_q));

  // R9
  read_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i != 2'd0) |-> (rdata_o == '0));

  // R9
  unused_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i[1]) |=> ($stable(own_q) && $stable(inv_q)));
endmodule

bind cs_out_ctrl cs_out_ctrl_chk #(.NUM_LINES(NUM_LINES)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .wr_en_i(wr_en_i),
  .addr_i (addr_i),
  .wdata_i(wdata_i),
  .rdata_o(rdata_o),
  .hw_cs_i(hw_cs_i),
  .pins_o (pins_o),
  .own_q  (own_q),
  .inv_q  (inv_q),
  .lvl_q  (lvl_q)
);

// File: tb/tb_cs_out_ctrl.sv
`timescale 1ns/1ps
module tb_cs_out_ctrl;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  addr_i = 2'd0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic [7:0]  hw_cs_i = 8'hFF;
  logic [7:0]  pins_o;

  int checks = 0;
  int fails  = 0;

  // behavioural reference state
  logic [15:0] m_setup;
  logic [7:0]  m_lvl;

  always #5 clk_i = ~clk_i;

  cs_out_ctrl dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .hw_cs_i(hw_cs_i), .pins_o(pins_o)
  );

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_setup <= 16'h0000;
      m_lvl   <= 8'hFF;
    end else if (wr_en_i) begin
      if (addr_i == 2'd0) m_setup <= wdata_i;
      else if (addr_i == 2'd1) begin
        for (int n = 0; n < 8; n++) begin
          if (wdata_i[8+n])   m_lvl[n] <= 1'b1;
          else if (wdata_i[n]) m_lvl[n] <= 1'b0;
        end
      end
    end
  end

  function automatic logic [7:0] exp_pins();
    logic [7:0] r;
    for (int n = 0; n < 8; n++)
      r[n] = (m_setup[8+n] ? hw_cs_i[n] : m_lvl[n]) ^ m_setup[n];
    return r;
  endfunction

  function automatic logic [15:0] exp_rd();
    return (addr_i == 2'd0) ? m_setup : 16'h0000;
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock comparison against the model (R7, R8 pins; R9 read data)
  always @(posedge clk_i) begin
    #2;
    if (rst_ni) begin
      check("R7/R8 pins per-cycle", {8'h00, pins_o}, {8'h00, exp_pins()});
      check("R2/R9 rdata per-cycle", rdata_o, exp_rd());
    end
  end

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0; addr_i = 2'd0;
    #1;
  endtask

  task automatic rd_chk(input string tag, input logic [1:0] a, input logic [15:0] exp);
    @(negedge clk_i);
    addr_i = a;
    #1;
    check(tag, rdata_o, exp);
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk_i);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    #1;
    check("R1 pins after reset", {8'h00, pins_o}, 16'h00FF);
    check("R1 setup after reset", rdata_o, 16'h0000);
    rst_ni = 1'b1;
    @(negedge clk_i);

    wr(2'd1, 16'h000F);
    check("R4 clear lines 3:0", {8'h00, pins_o}, 16'h00F0);
    wr(2'd1, 16'h0300);
    check("R3 set lines 1:0", {8'h00, pins_o}, 16'h00F3);
    wr(2'd1, 16'h0000);
    check("R5 zero write holds", {8'h00, pins_o}, 16'h00F3);
    wr(2'd1, 16'h0010);
    check("R4 clear line 4", {8'h00, pins_o}, 16'h00E3);
    wr(2'd1, 16'h1010);
    check("R6 set beats clear", {8'h00, pins_o}, 16'h00F3);
    wr(2'd1, 16'h0404);
    check("R6 set beats clear line 2", {8'h00, pins_o}, 16'h00F7);

    wr(2'd0, 16'h0005);
    rd_chk("R2 setup readback", 2'd0, 16'h0005);
    check("R7 inversion", {8'h00, pins_o}, 16'h00F2);

    @(negedge clk_i); hw_cs_i = 8'hFD;
    wr(2'd0, 16'h0301);
    check("R8 owned lines follow engine", {8'h00, pins_o}, 16'h00F4);
    wr(2'd1, 16'h0003);
    check("R8 owned lines ignore stored", {8'h00, pins_o}, 16'h00F4);
    @(negedge clk_i); hw_cs_i = 8'hFE; #1;
    check("R8 engine toggle", {8'h00, pins_o}, 16'h00F7);
    wr(2'd0, 16'h0001);
    check("R8 stored level after release", {8'h00, pins_o}, 16'h00F5);

    rd_chk("R9 drive reads zero", 2'd1, 16'h0000);
    wr(2'd2, 16'hFFFF);
    wr(2'd3, 16'h00FF);
    rd_chk("R9 unused addr reads zero", 2'd3, 16'h0000);
    rd_chk("R9 setup unchanged", 2'd0, 16'h0001);
    check("R9 pins unchanged", {8'h00, pins_o}, 16'h00F5);

    for (int i = 0; i < 400; i++) begin
      @(negedge clk_i);
      wr_en_i = ($urandom % 3) != 0;
      addr_i  = 2'($urandom);
      wdata_i = 16'($urandom);
      hw_cs_i = 8'($urandom);
    end
    @(negedge clk_i);
    wr_en_i = 1'b0;
    @(negedge clk_i);
    #1;
    check("R5 pins after random run", {8'h00, pins_o}, {8'h00, exp_pins()});

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule